// File: doc/BRIEF.md
# Parallel Bus Cycle Master with Wait-State Control

This block turns a single-byte request from local logic into one complete cycle on an 8-bit parallel peripheral bus of the classic PC expansion style. The request names a target space (memory or I/O), a direction, an address and, for writes, a data byte. The block then runs a cycle with four base phases: an address phase that pulses the address latch enable, a command phase in which one active-low strobe goes low, a hold phase, and an end phase in which the strobe is released and completion is reported.

Slow targets stretch the cycle by holding the ready line low. Each low sample taken in the command phase, and in every inserted wait phase, adds one wait cycle. The number of wait cycles has a hard cap. When the cap is reached the cycle finishes anyway and reports a timeout. Memory cycles drive the full memory address width. I/O cycles drive only the narrower I/O address and hold the upper address lines at zero.

Top module: `xbus_cyc_master`

## Requirements
- R1: While reset is held and after its release, busy and done are 0, the latch enable is 0, all four strobes are high, the data driver is off, the bus address is 0 and the read data register is 0.
- R2: A request presented while busy is 0 is taken at the next rising edge. In the following cycle the latch enable is high for exactly one cycle, and no strobe is low in that cycle.
- R3: With ready high, a cycle occupies exactly four clock cycles from latch enable to done. The strobe is low for exactly two of them (the second and third). Done is a one-cycle pulse in the fourth, with all strobes high, and busy drops in the cycle after it.
- R4: Exactly one strobe is used per cycle, chosen by space and direction: memory read uses memr_n, memory write uses memw_n, I/O read uses ior_n, I/O write uses iow_n. No two strobes are ever low together.
- R5: Ready is sampled at the end of the command phase and at the end of each wait phase. Each low sample inserts one more wait cycle before the hold phase, so the strobe stays low for 2 + N cycles for N low samples.
- R6: At most MAX_WAIT (default 6) wait cycles are inserted. If ready is still low at the end of the last allowed wait, the cycle continues and timeout_o is 1 when done pulses. timeout_o is 0 for a cycle that ended on a high ready sample, and it clears when the next request is accepted.
- R7: The bus address is valid and constant from the latch-enable cycle through the done cycle, and it is 0 when idle. In memory cycles it equals the request address. In I/O cycles its upper MEM_AW-IO_AW bits (default bits 19..16) are 0.
- R8: The write data byte is driven, with the data enable high, in every cycle of a write in which the strobe is low, and only then. Read cycles never enable the data driver.
- R9: For a read, rdata_o equals the bus data sampled on the final edge of the last strobe-low cycle, and it is valid when done pulses.
- R10: A request raised while busy is 1 is dropped. The running cycle keeps its address, strobe and length, and no second cycle starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid_i | input | 1 | Request strobe from local logic |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_mem_i | input | 1 | 1 = memory space, 0 = I/O space |
| req_addr_i | input | MEM_AW | Request address |
| req_wdata_i | input | DW | Write data byte |
| busy_o | output | 1 | Cycle in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | DW | Captured read data |
| timeout_o | output | 1 | Last cycle ended on the wait cap |
| bus_addr_o | output | MEM_AW | Bus address lines |
| bus_ale_o | output | 1 | Address latch enable |
| bus_memr_n_o | output | 1 | Memory read strobe, active low |
| bus_memw_n_o | output | 1 | Memory write strobe, active low |
| bus_ior_n_o | output | 1 | I/O read strobe, active low |
| bus_iow_n_o | output | 1 | I/O write strobe, active low |
| bus_wdata_o | output | DW | Data driven onto the bus |
| bus_data_oe_o | output | 1 | Data driver enable |
| bus_data_i | input | DW | Data sampled from the bus |
| bus_rdy_i | input | 1 | Target ready, low inserts wait cycles |

## Verification
The bench goes after the wait-count boundary. It runs cycles with exactly the cap of low ready samples, with one more than the cap, and with far more. A counter that is off by one would stretch the strobe by one cycle too many or too few, or would flag a timeout at the cap itself. On reads it presents the correct byte only in the last strobe-low cycle, so a capture one edge early or late returns the inverted byte. It issues I/O requests with the upper address bits set, and it raises new requests in the middle of busy cycles. A design that failed to clear the upper bits, or that accepted the stray request, would show a wrong address, a second latch enable or a shifted strobe.

// File: rtl/xbus_pkg.sv
package xbus_pkg;
   typedef enum logic [2:0] {
      CY_IDLE = 3'd0,
      CY_ADDR = 3'd1,
      CY_CMD  = 3'd2,
      CY_WAIT = 3'd3,
      CY_HOLD = 3'd4,
      CY_END  = 3'd5
   } cyc_state_e;
endpackage

// File: rtl/xbus_seq.sv
module xbus_seq
   import xbus_pkg::*;
#(
   parameter int MAX_WAIT = 6
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       start_i,
   input  logic       rdy_i,
   output cyc_state_e state_o,
   output logic       timeout_o
);
   localparam int WCW = $clog2(MAX_WAIT + 1);
   localparam logic [WCW-1:0] WLIM = WCW'(MAX_WAIT);
   localparam logic [WCW-1:0] WONE = WCW'(1);

   cyc_state_e     st_q;
   logic [WCW-1:0] wcnt_q;
   logic           tmo_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= CY_IDLE;
         wcnt_q <= '0;
         tmo_q  <= 1'b0;
      end else begin
         case (st_q)
            CY_IDLE: if (start_i) begin
               st_q  <= CY_ADDR;
               tmo_q <= 1'b0;
            end
            CY_ADDR: st_q <= CY_CMD;
            CY_CMD: begin
               if (rdy_i) st_q <= CY_HOLD;
               else begin
                  st_q   <= CY_WAIT;
                  wcnt_q <= WONE;
               end
            end
            CY_WAIT: begin
               if (rdy_i) st_q <= CY_HOLD;
               else if (wcnt_q == WLIM) begin
                  st_q  <= CY_HOLD;
                  tmo_q <= 1'b1;
               end else wcnt_q <= wcnt_q + WONE;
            end
            CY_HOLD: st_q <= CY_END;
            default: st_q <= CY_IDLE;
         endcase
      end
   end

   assign state_o   = st_q;
   assign timeout_o = tmo_q;
endmodule

// File: rtl/xbus_strobe_dec.sv
module xbus_strobe_dec (
   input  logic active_i,
   input  logic is_mem_i,
   input  logic is_wr_i,
   output logic memr_n_o,
   output logic memw_n_o,
   output logic ior_n_o,
   output logic iow_n_o
);
   always_comb begin
      memr_n_o = ~(active_i &  is_mem_i & ~is_wr_i);
      memw_n_o = ~(active_i &  is_mem_i &  is_wr_i);
      ior_n_o  = ~(active_i & ~is_mem_i & ~is_wr_i);
      iow_n_o  = ~(active_i & ~is_mem_i &  is_wr_i);
   end
endmodule

// File: rtl/xbus_cyc_master.sv
module xbus_cyc_master
   import xbus_pkg::*;
#(
   parameter int MEM_AW   = 20,
   parameter int IO_AW    = 16,
   parameter int DW       = 8,
   parameter int MAX_WAIT = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid_i,
   input  logic              req_write_i,
   input  logic              req_mem_i,
   input  logic [MEM_AW-1:0] req_addr_i,
   input  logic [DW-1:0]     req_wdata_i,
   output logic              busy_o,
   output logic              done_o,
   output logic [DW-1:0]     rdata_o,
   output logic              timeout_o,
   output logic [MEM_AW-1:0] bus_addr_o,
   output logic              bus_ale_o,
   output logic              bus_memr_n_o,
   output logic              bus_memw_n_o,
   output logic              bus_ior_n_o,
   output logic              bus_iow_n_o,
   output logic [DW-1:0]     bus_wdata_o,
   output logic              bus_data_oe_o,
   input  logic [DW-1:0]     bus_data_i,
   input  logic              bus_rdy_i
);
   localparam int PAD_W = MEM_AW - IO_AW;

   if (IO_AW < 1 || IO_AW > MEM_AW) begin : g_bad_aw
      $error("xbus_cyc_master: IO_AW must lie in 1..MEM_AW");
   end
   if (DW < 1) begin : g_bad_dw
      $error("xbus_cyc_master: DW must be at least 1");
   end
   if (MAX_WAIT < 1) begin : g_bad_wait
      $error("xbus_cyc_master: MAX_WAIT must be at least 1");
   end

   cyc_state_e        state;
   logic              start;
   logic              strobe_on;
   logic              mem_q, wr_q;
   logic [MEM_AW-1:0] addr_q;
   logic [DW-1:0]     wdata_q, rdata_q;
   logic [MEM_AW-1:0] steered_addr;

   assign start = req_valid_i && (state == CY_IDLE);

   if (PAD_W > 0) begin : g_narrow_io
      assign steered_addr = req_mem_i ? req_addr_i
                                      : {{PAD_W{1'b0}}, req_addr_i[IO_AW-1:0]};
   end else begin : g_full_io
      assign steered_addr = req_addr_i;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mem_q   <= 1'b0;
         wr_q    <= 1'b0;
         addr_q  <= '0;
         wdata_q <= '0;
         rdata_q <= '0;
      end else begin
         if (start) begin
            mem_q   <= req_mem_i;
            wr_q    <= req_write_i;
            addr_q  <= steered_addr;
            wdata_q <= req_wdata_i;
         end
         if (state == CY_HOLD && !wr_q) rdata_q <= bus_data_i;
      end
   end

   xbus_seq #(.MAX_WAIT(MAX_WAIT)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start),
      .rdy_i    (bus_rdy_i),
      .state_o  (state),
      .timeout_o(timeout_o)
   );

   assign strobe_on = (state == CY_CMD) || (state == CY_WAIT) || (state == CY_HOLD);

   xbus_strobe_dec u_dec (
      .active_i(strobe_on),
      .is_mem_i(mem_q),
      .is_wr_i (wr_q),
      .memr_n_o(bus_memr_n_o),
      .memw_n_o(bus_memw_n_o),
      .ior_n_o (bus_ior_n_o),
      .iow_n_o (bus_iow_n_o)
   );

   assign busy_o        = (state != CY_IDLE);
   assign done_o        = (state == CY_END);
   assign bus_ale_o     = (state == CY_ADDR);
   assign bus_addr_o    = busy_o ? addr_q : '0;
   assign bus_data_oe_o = strobe_on && wr_q;
   assign bus_wdata_o   = bus_data_oe_o ? wdata_q : '0;
   assign rdata_o       = rdata_q;
endmodule

// File: rtl/xbus_cyc_master_chk.sv
module xbus_cyc_master_chk #(
   parameter int MEM_AW   = 20,
   parameter int IO_AW    = 16,
   parameter int MAX_WAIT = 6
) (
   input logic              clk,
   input logic              rst_n,
   input logic              busy_o,
   input logic              done_o,
   input logic              bus_ale_o,
   input logic              bus_memr_n_o,
   input logic              bus_memw_n_o,
   input logic              bus_ior_n_o,
   input logic              bus_iow_n_o,
   input logic              bus_data_oe_o,
   input logic [MEM_AW-1:0] bus_addr_o
);
   logic [3:0] low;
   int         lowrun;

   assign low = ~{bus_memr_n_o, bus_memw_n_o, bus_ior_n_o, bus_iow_n_o};

   always_ff @(posedge clk) begin
      if (!rst_n) lowrun <= 0;
      else if (low != 4'b0) lowrun <= lowrun + 1;
      else lowrun <= 0;
   end

   a_r4_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(low) <= 1);
   a_r2_ale_single: assert property (@(posedge clk) disable iff (!rst_n)
      bus_ale_o |=> !bus_ale_o);
   a_r2_ale_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      bus_ale_o |-> (low == 4'b0));
   a_r3_done_released: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (low == 4'b0));
   a_r3_done_then_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !busy_o);
   a_r6_wait_cap: assert property (@(posedge clk) disable iff (!rst_n)
      lowrun <= MAX_WAIT + 2);
   a_r7_addr_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && $past(busy_o)) |-> $stable(bus_addr_o));
   a_r8_oe_on_write: assert property (@(posedge clk) disable iff (!rst_n)
      bus_data_oe_o |-> (low[2] || low[0]));

   if (IO_AW < MEM_AW) begin : g_io_pad
      a_r7_io_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
         (low[1] || low[0]) |-> (bus_addr_o[MEM_AW-1:IO_AW] == '0));
   end
endmodule

bind xbus_cyc_master xbus_cyc_master_chk #(
   .MEM_AW(MEM_AW), .IO_AW(IO_AW), .MAX_WAIT(MAX_WAIT)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .busy_o       (busy_o),
   .done_o       (done_o),
   .bus_ale_o    (bus_ale_o),
   .bus_memr_n_o (bus_memr_n_o),
   .bus_memw_n_o (bus_memw_n_o),
   .bus_ior_n_o  (bus_ior_n_o),
   .bus_iow_n_o  (bus_iow_n_o),
   .bus_data_oe_o(bus_data_oe_o),
   .bus_addr_o   (bus_addr_o)
);

// File: tb/xbus_cyc_master_tb.sv
`timescale 1ns/1ps
module xbus_cyc_master_tb;
   localparam int MAXW = 6;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_write = 1'b0, req_mem = 1'b0;
   logic [19:0] req_addr = '0;
   logic [7:0]  req_wdata = '0;
   logic        busy, done, tmo, ale, memr_n, memw_n, ior_n, iow_n, oe;
   logic [7:0]  rdata, wdo;
   logic [7:0]  bus_din = '0;
   logic [19:0] baddr;
   logic        rdy = 1'b1;

   int n_vec = 0;
   int n_bad = 0;
   bit finished = 0;

   typedef struct {
      bit mem; bit wr; logic [19:0] addr; logic [7:0] wdata; logic [7:0] rdata;
      int width; bit tmo;
   } exp_t;
   exp_t q[$];

   always #4 clk = ~clk;

   xbus_cyc_master u_dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid_i(req_valid), .req_write_i(req_write), .req_mem_i(req_mem),
      .req_addr_i(req_addr), .req_wdata_i(req_wdata),
      .busy_o(busy), .done_o(done), .rdata_o(rdata), .timeout_o(tmo),
      .bus_addr_o(baddr), .bus_ale_o(ale),
      .bus_memr_n_o(memr_n), .bus_memw_n_o(memw_n), .bus_ior_n_o(ior_n), .bus_iow_n_o(iow_n),
      .bus_wdata_o(wdo), .bus_data_oe_o(oe), .bus_data_i(bus_din), .bus_rdy_i(rdy)
   );

   task automatic chk(input bit ok, input string rq, input string what,
                      input logic [31:0] act, input logic [31:0] expv);
      n_vec++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual 0x%0h expected 0x%0h", rq, what, act, expv);
      end
   endtask

   function automatic logic [3:0] strobe_code(bit mem, bit wr);
      // bit order {memr, memw, ior, iow}, a set bit means that strobe was low
      if (mem) return wr ? 4'b0100 : 4'b1000;
      return wr ? 4'b0001 : 4'b0010;
   endfunction

   function automatic logic [3:0] lows();
      return ~{memr_n, memw_n, ior_n, iow_n};
   endfunction

   // Monitor: pops expected items and compares as cycles complete
   initial begin
      bit in_cyc = 0;
      bit ale_prev = 0;
      int width = 0;
      int len = 0;
      logic [3:0] code = '0;
      exp_t e;
      forever begin
         @(negedge clk);
         if (rst_n) begin
            if (ale_prev) chk(!ale, "R2", "latch enable longer than one cycle", 32'(ale), 0);
            if (ale) begin
               chk(!in_cyc && q.size() > 0, "R10", "unexpected cycle start", 32'(q.size()), 1);
               chk(lows() == 4'b0, "R2", "strobe low with latch enable", 32'(lows()), 0);
               in_cyc = 1; width = 0; len = 0; code = '0;
            end
            if (in_cyc && q.size() > 0) begin
               e = q[0];
               len++;
               chk(baddr == e.addr, "R7", "bus address", 32'(baddr), 32'(e.addr));
               chk(busy, "R10", "busy during cycle", 32'(busy), 1);
               if (lows() != 4'b0) begin
                  width++;
                  code = code | lows();
                  chk($countones(lows()) == 1, "R4", "strobe count", 32'(lows()), 32'(strobe_code(e.mem, e.wr)));
                  chk(oe == e.wr, "R8", "data enable in strobe", 32'(oe), 32'(e.wr));
                  if (e.wr) chk(wdo == e.wdata, "R8", "write data", 32'(wdo), 32'(e.wdata));
               end else begin
                  chk(!oe, "R8", "data enable outside strobe", 32'(oe), 0);
               end
               if (done) begin
                  void'(q.pop_front());
                  in_cyc = 0;
                  chk(width == e.width, "R5", "strobe width", 32'(width), 32'(e.width));
                  chk(len == e.width + 2, "R3", "cycle length", 32'(len), 32'(e.width + 2));
                  chk(code == strobe_code(e.mem, e.wr), "R4", "strobe select", 32'(code), 32'(strobe_code(e.mem, e.wr)));
                  chk(tmo == e.tmo, "R6", "timeout flag", 32'(tmo), 32'(e.tmo));
                  if (!e.wr) chk(rdata == e.rdata, "R9", "read data", 32'(rdata), 32'(e.rdata));
               end
            end else begin
               chk(!busy && !done && !oe && lows() == 4'b0 && baddr == '0, "R1",
                   "idle outputs", {busy, done, oe, lows(), baddr}, 0);
            end
            ale_prev = ale;
         end
      end
   end

   // Driver: pushes the expected item, then plays the target side
   task automatic xfer(input bit mem, input bit wr, input logic [19:0] a,
                       input logic [7:0] wd, input logic [7:0] rd,
                       input int waits, input bit poke);
      exp_t e;
      int c = 0;
      bit fin = 0;
      int w = (waits > MAXW) ? MAXW : waits;
      e.mem = mem; e.wr = wr; e.wdata = wd; e.rdata = rd;
      e.addr = mem ? a : {4'h0, a[15:0]};
      e.width = 2 + w; e.tmo = (waits > MAXW);
      q.push_back(e);
      req_valid = 1; req_mem = mem; req_write = wr; req_addr = a; req_wdata = wd;
      rdy = 1; bus_din = ~rd;
      @(negedge clk);
      req_valid = 0; req_addr = ~a; req_wdata = ~wd; req_mem = !mem; req_write = !wr;
      while (!fin) begin
         @(negedge clk);
         req_valid = 0;
         if (lows() != 4'b0) c++;
         if (done) fin = 1;
         rdy = (c > waits);
         bus_din = (c == e.width) ? rd : ~rd;
         if (poke && c == 1) begin  // R10: request while busy
            req_valid = 1; req_addr = a ^ 20'h5A5A5; req_mem = !mem;
         end
      end
      rdy = 1;
      @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(!busy && !done && !ale && lows() == 4'b0 && !oe && baddr == '0 && rdata == '0,
          "R1", "reset state", {busy, done, ale, oe, lows()}, 0);
      rst_n = 1;
      @(negedge clk);
      chk(!busy && !done && !tmo, "R1", "after reset", {busy, done, tmo}, 0);
      xfer(1, 0, 20'hABCDE, 8'h00, 8'h3C, 0, 0);   // R3 R4 R9
      xfer(1, 1, 20'h12345, 8'hA7, 8'h00, 0, 0);   // R8
      xfer(0, 0, 20'hF0F0F, 8'h00, 8'hC3, 0, 0);   // R7 upper bits cleared
      xfer(0, 1, 20'h9ABCD, 8'h5E, 8'h00, 2, 0);   // R5
      xfer(1, 0, 20'h00F01, 8'h00, 8'h81, 3, 1);   // R10 R5 R9
      xfer(1, 1, 20'h7FFFF, 8'h11, 8'h00, 6, 0);   // R6 at the cap, no timeout
      xfer(0, 0, 20'hE1234, 8'h00, 8'h96, 7, 0);   // R6 one past the cap
      xfer(1, 0, 20'h55555, 8'h00, 8'h6A, 20, 1);  // R6 long stall
      xfer(1, 0, 20'h0AAAA, 8'h00, 8'hF1, 0, 0);   // R6 flag cleared
      xfer(0, 1, 20'h3C3C3, 8'hE2, 8'h00, 1, 1);   // R10 R5 R8
      repeat (4) @(negedge clk);
      chk(q.size() == 0, "R3", "all cycles completed", 32'(q.size()), 0);
      chk(!tmo, "R6", "flag after clean cycle", 32'(tmo), 0);
      if (!finished) begin
         finished = 1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         n_bad++;
         $display("FAIL R3 watchdog: actual 0x1 expected 0x0");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule